// File: doc/BRIEF.md
# Nibble Parity Calibration Decoder

The decoder receives a frame of eight protected bytes, one byte per accepted cycle, and recovers a 32-bit calibration word from them. Each protected byte carries a four-bit data nibble together with four parity bits. The parity bits are pairwise XORs of the nibble bits. Every byte is checked as it arrives. The eight nibbles are then packed into the word, and the word is split into a lower and an upper 16-bit calibration point.

The code detects errors but does not correct them. If even one byte of a frame fails its check, the frame is reported as corrupt. Both calibration outputs are then forced to zero, so that any correction stage downstream stays switched off. Results are registered and announced with a one-cycle valid pulse. A new frame may begin in the very cycle that the previous result is announced.

Top module: `nibpar_cal_decoder`

## Requirements
- R1: A protected byte passes only if it is bit-for-bit equal to the byte rebuilt from its own nibble. The rebuilt byte has the data nibble d3..d0 in bits 3:0, d0^d1 in bit 4, d2^d3 in bit 5, d0^d2 in bit 6 and d1^d3 in bit 7.
- R2: The nibble of the k-th accepted byte of a frame (k = 0..7) occupies bits 4k+3:4k of the 32-bit word. Byte 2i therefore gives the low nibble and byte 2i+1 the high nibble of word byte i, and word byte 0 is the least significant.
- R3: For a frame that passes, `cal_lo` equals word bits 15:0 and `cal_hi` equals word bits 31:16.
- R4: `out_valid` is high for exactly one cycle, in the cycle after the eighth byte of a frame is accepted. It is low at all other times.
- R5: If any byte of a frame fails R1, the result carries `out_err` = 1 and `cal_lo` = `cal_hi` = 0. A result from a passing frame carries `out_err` = 0.
- R6: A byte is accepted only in a cycle with `in_valid` high. Idle cycles of any length between the bytes of a frame neither shift nor alter the frame.
- R7: `cal_lo`, `cal_hi` and `out_err` keep the last result until the next `out_valid` pulse.
- R8: Each frame is judged on its own bytes only, so an error never carries into the next frame. The first byte of the next frame may be accepted in the cycle that `out_valid` is high.
- R9: Synchronous reset clears all outputs to zero and discards any partly received frame. The next accepted byte is byte 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_byte` for acceptance this cycle |
| in_byte | input | 8 | Protected byte: nibble in bits 3:0, parity in bits 7:4 |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Last result came from a corrupt frame |
| cal_lo | output | 16 | Lower calibration point (word bits 15:0) |
| cal_hi | output | 16 | Upper calibration point (word bits 31:16) |

## Verification
The publication of a finished result and the acceptance of the first byte of the next frame can fall in the same cycle. In that cycle the collector has to restart its byte count and clear its error memory while the output registers still carry the previous frame. The bench provokes this by sending frames back to back with no idle cycle after the eighth byte. Some of these pairs are a corrupt frame followed by a clean one. Each published result is judged against a word and error flag that the bench computes from its own encoder, and the following frame must then decode as if it were the first.

// File: rtl/nibpar_pkg.sv
package nibpar_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    typedef logic [NIB_W-1:0] nibble_t;

    // par[0]=bit4, par[1]=bit5, par[2]=bit6, par[3]=bit7
    typedef struct packed {
        logic [NIB_W-1:0] par;
        nibble_t          data;
    } prot_byte_t;

    typedef struct packed {
        logic    ok;
        nibble_t nib;
    } chk_t;

    function automatic prot_byte_t protect(input nibble_t n);
        prot_byte_t p;
        p.data   = n;
        p.par[0] = n[0] ^ n[1];
        p.par[1] = n[2] ^ n[3];
        p.par[2] = n[0] ^ n[2];
        p.par[3] = n[1] ^ n[3];
        return p;
    endfunction

endpackage

// File: rtl/nibpar_byte_check.sv
module nibpar_byte_check
    import nibpar_pkg::*;
(
    input  logic [BYTE_W-1:0] raw,
    output chk_t              res
);

    prot_byte_t rebuilt;

    always_comb begin
        rebuilt = protect(raw[NIB_W-1:0]);
        res.nib = raw[NIB_W-1:0];
        res.ok  = (rebuilt == prot_byte_t'(raw));
    end

endmodule

// File: rtl/nibpar_collect.sv
module nibpar_collect
    import nibpar_pkg::*;
#(
    parameter int STORED = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  chk_t                    cur,
    output logic                    done,
    output logic                    err_now,
    output logic [STORED*NIB_W-1:0] word
);

    localparam int CNT_W = (STORED > 1) ? $clog2(STORED) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STORED - 1);

    logic [CNT_W-1:0] cnt;
    logic             err_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            err_acc <= 1'b0;
        end else if (in_valid) begin
            cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
            err_acc <= (cnt == '0) ? !cur.ok : (err_acc | !cur.ok);
        end
    end

    for (genvar k = 0; k < STORED - 1; k++) begin : g_slot
        nibble_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (in_valid && cnt == CNT_W'(k))
                q <= cur.nib;
        end
        assign word[k*NIB_W +: NIB_W] = q;
    end
    assign word[(STORED-1)*NIB_W +: NIB_W] = cur.nib;

    assign done    = in_valid && (cnt == LAST);
    assign err_now = err_acc | !cur.ok;

    // R6: no accepted byte, no movement of the frame position
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt));

    // R8: after a frame completes, the next byte starts a new frame
    a_r8_frame_restart: assert property (@(posedge clk) disable iff (rst)
        done |=> (cnt == '0));

endmodule

// File: rtl/nibpar_cal_decoder.sv
module nibpar_cal_decoder
    import nibpar_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [7:0]              in_byte,
    output logic                    out_valid,
    output logic                    out_err,
    output logic [DATA_BYTES*4-1:0] cal_lo,
    output logic [DATA_BYTES*4-1:0] cal_hi
);

    localparam int STORED = 2 * DATA_BYTES;
    localparam int WORD_W = STORED * NIB_W;
    localparam int HALF_W = WORD_W / 2;

    chk_t              chk;
    logic              done;
    logic              err_now;
    logic [WORD_W-1:0] word;

    nibpar_byte_check u_check (
        .raw (in_byte),
        .res (chk)
    );

    nibpar_collect #(.STORED(STORED)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .cur      (chk),
        .done     (done),
        .err_now  (err_now),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            cal_lo    <= '0;
            cal_hi    <= '0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_err <= err_now;
                cal_lo  <= err_now ? '0 : word[HALF_W-1:0];
                cal_hi  <= err_now ? '0 : word[WORD_W-1:HALF_W];
            end
        end
    end

    // R4: the strobe never lasts more than one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5: a corrupt result never exposes calibration data
    a_r5_err_zeroed: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (cal_lo == '0 && cal_hi == '0));

    // R7: outputs only move together with the strobe
    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(cal_lo) && $stable(cal_hi) && $stable(out_err)));

endmodule

// File: tb/nibpar_cal_decoder_tb.sv
module nibpar_cal_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_err;
    logic [15:0] cal_lo;
    logic [15:0] cal_hi;

    int total = 0;
    int bad = 0;
    int bcnt = 0;
    bit finished = 0;

    logic [15:0] exp_lo = '0, exp_hi = '0;
    logic        exp_err = 1'b0;
    logic [15:0] last_lo = '0, last_hi = '0;
    logic        last_err = 1'b0;

    always #2 clk = ~clk;

    nibpar_cal_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_err(out_err), .cal_lo(cal_lo), .cal_hi(cal_hi)
    );

    function automatic logic [7:0] enc(input logic [3:0] n);
        return {n[1]^n[3], n[0]^n[2], n[2]^n[3], n[0]^n[1], n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        bcnt++;
        if (bcnt == 8) begin
            bcnt = 0;
            check(out_valid === 1'b1, "R4 valid pulse", 32'(out_valid), 1);
            check(out_err === exp_err, "R5 error flag", 32'(out_err), 32'(exp_err));
            check(cal_lo === exp_lo, "R3 cal_lo", 32'(cal_lo), 32'(exp_lo));
            check(cal_hi === exp_hi, "R3 cal_hi", 32'(cal_hi), 32'(exp_hi));
            last_lo = exp_lo; last_hi = exp_hi; last_err = exp_err;
        end else begin
            check(out_valid === 1'b0, "R4 no early valid", 32'(out_valid), 0);
        end
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        in_byte  = 8'($urandom);
        @(negedge clk);
        check(out_valid === 1'b0, "R6 idle no valid", 32'(out_valid), 0);
        check(cal_lo === last_lo && cal_hi === last_hi && out_err === last_err,
              "R7 hold", {cal_hi, cal_lo}, {last_hi, last_lo});
    endtask

    // bad_idx < 0: clean frame; otherwise byte bad_idx gets bad_mask xor'ed in
    task automatic send_frame(input logic [31:0] w, input int bad_idx,
                              input logic [7:0] bad_mask, input int max_gap);
        logic [7:0] fr [8];
        for (int k = 0; k < 8; k++) fr[k] = enc(w[4*k +: 4]);
        if (bad_idx >= 0) fr[bad_idx] = fr[bad_idx] ^ bad_mask;
        exp_err = (bad_idx >= 0) && (bad_mask != 8'h00);
        exp_lo  = exp_err ? 16'h0 : w[15:0];
        exp_hi  = exp_err ? 16'h0 : w[31:16];
        for (int k = 0; k < 8; k++) begin
            drive_byte(fr[k]);
            if (k < 7 && max_gap > 0) begin
                int g = $urandom_range(max_gap, 0);
                for (int j = 0; j < g; j++) idle_cycle();
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005eed1));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0, "R9 reset valid", 32'(out_valid), 0);
        check(out_err === 1'b0, "R9 reset err", 32'(out_err), 0);
        check(cal_lo === 16'h0 && cal_hi === 16'h0, "R9 reset cal", {cal_hi, cal_lo}, 0);

        // R2/R3 directed patterns
        send_frame(32'h0000_0000, -1, 8'h00, 0);
        send_frame(32'hFFFF_FFFF, -1, 8'h00, 0);
        send_frame(32'h1234_ABCD, -1, 8'h00, 2);
        idle_cycle();
        send_frame(32'h8421_0F5A, -1, 8'h00, 0);

        // R1: parity-only flips and a non-code byte
        send_frame(32'h5555_AAAA, 3, 8'h10, 0);
        send_frame(32'h7E81_C33C, 5, 8'h80, 1);
        send_frame(32'h0000_000F, 0, 8'hF0, 0);

        // R5/R8: error in last byte, then clean back-to-back
        send_frame(32'hDEAD_BEEF, 7, 8'h01, 0);
        send_frame(32'hCAFE_F00D, -1, 8'h00, 0);
        // error in first byte, then clean
        send_frame(32'h0123_4567, 0, 8'h40, 0);
        send_frame(32'h89AB_CDEF, -1, 8'h00, 0);
        idle_cycle();

        // R9: reset in the middle of a frame
        drive_byte(enc(4'h3));
        drive_byte(enc(4'h9));
        drive_byte(enc(4'hC));
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        bcnt = 0;
        last_lo = '0; last_hi = '0; last_err = 1'b0;
        @(negedge clk);
        check(cal_lo === 16'h0 && cal_hi === 16'h0 && out_err === 1'b0,
              "R9 mid-frame reset clears", {cal_hi, cal_lo}, 0);
        send_frame(32'h2468_ACE0, -1, 8'h00, 1);

        // Random mix
        for (int f = 0; f < 60; f++) begin
            logic [31:0] w = $urandom;
            int bi = -1;
            logic [7:0] m = 8'h00;
            if ($urandom_range(3, 0) == 0) begin
                bi = $urandom_range(7, 0);
                m  = 8'(1 << $urandom_range(7, 0));
                if ($urandom_range(3, 0) == 0) m = m | 8'(1 << $urandom_range(7, 0));
                if (m == 8'h00) bi = -1;
            end
            send_frame(w, bi, m, $urandom_range(2, 0));
            if ($urandom_range(1, 0) == 0) idle_cycle();
        end

        idle_cycle();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule